// File: doc/BRIEF.md
# Interrupt Acceptance and Stack-Select Unit

This unit sits next to a small processor core. In each clock cycle it picks at most one interrupt for the core to take. It reports that choice as a one-cycle accept pulse together with a 6-bit vector number. It also keeps the flag that chooses between the user stack and the interrupt stack, and updates that flag when an interrupt is entered and when a handler returns.

Candidates come from two places:

- **Maskable peripheral sources.** Each source has its own programmable priority level. These sources are gated by a global enable flag and by the processor's current priority level.
- **Non-maskable software traps.** The decoder strobes these: undefined opcode, the overflow check, break, and a numbered software interrupt that carries a 6-bit number.

Vectors 0 to 31 are shared by the peripheral sources and by the low software-interrupt numbers. Entering through any of these vectors saves the stack flag and switches to the interrupt stack. Every other vector leaves the stack flag alone. Each entry pushes a small frame onto an internal last-in-first-out store, so that returns from nested handlers undo exactly the changes made on the way in.

Top module: `irq_accept_unit`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge): stk_sel=1, ie_flag=0, acc_pulse=0, nest_err=0, and the frame store is empty.
- R2: A peripheral request i is accepted only when ie_flag=1 and its level irq_lvl[i*3+:3] is strictly greater than cpu_lvl.
- R3: Among eligible peripheral requests the highest level wins; on equal levels the lowest index wins; peripheral i yields vector i.
- R4: A software strobe (trap_und, trap_ovchk with ovf_flag=1, trap_brk, swi_stb) is accepted regardless of ie_flag and cpu_lvl, and wins over any peripheral request in the same cycle.
- R5: Trap vectors are fixed: undefined opcode 60, overflow 61, break 62. swi_stb yields vector swi_num. Priority among simultaneous strobes is undefined opcode, overflow, break, numbered interrupt.
- R6: trap_ovchk with ovf_flag=0 causes no acceptance.
- R7: acc_pulse is high for one cycle, one clock after the request cycle, and acc_vec is valid in that same cycle.
- R8: Accepting a vector 0..31 clears stk_sel to 0 in the cycle of acc_pulse, after saving the prior value.
- R9: Accepting a vector 32..63 leaves stk_sel unchanged, and its later return also leaves stk_sel unchanged.
- R10: ret_stb pops the newest frame. If that frame came from a vector 0..31, stk_sel returns to the saved value one clock later. A return with an empty store changes nothing.
- R11: In a cycle with ret_stb high, no interrupt is accepted.
- R12: The frame store holds 8 frames. An accept while 8 are held drops the frame and sets nest_err, which stays set until reset.
- R13: ie_we=1 loads ie_wdata into ie_flag at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 32 | Peripheral request lines |
| irq_lvl | input | 96 | Priority level per source, 3 bits each, source i at [i*3+:3] |
| cpu_lvl | input | 3 | Current processor priority level |
| ie_we | input | 1 | Write strobe for the enable flag |
| ie_wdata | input | 1 | Value written to the enable flag |
| trap_und | input | 1 | Undefined-opcode strobe |
| trap_ovchk | input | 1 | Overflow-check instruction strobe |
| ovf_flag | input | 1 | Processor overflow flag |
| trap_brk | input | 1 | Break strobe |
| swi_stb | input | 1 | Numbered software-interrupt strobe |
| swi_num | input | 6 | Software-interrupt number |
| ret_stb | input | 1 | Return-from-interrupt strobe |
| acc_pulse | output | 1 | One-cycle accept pulse |
| acc_vec | output | 6 | Accepted vector number |
| stk_sel | output | 1 | Stack select flag (0 = interrupt stack) |
| ie_flag | output | 1 | Global interrupt enable flag |
| nest_err | output | 1 | Sticky frame-store overflow flag |

## Verification
Every result is registered, so acc_pulse, acc_vec, stk_sel, ie_flag and nest_err all reflect a request or strobe exactly one clock edge after the cycle in which it was presented. The same one-edge delay applies to the restore of stk_sel on a return. The bench changes inputs on the falling edge, lets one rising edge pass, and samples on the next falling edge. Because of this, each check reads the value due from precisely the stimulus just applied. The bench then clears the stimulus, so a held request cannot be counted twice.

// File: rtl/irq_acc_pkg.sv
package irq_acc_pkg;
    localparam int VEC_W = 6;
    localparam logic [VEC_W-1:0] VEC_UND = 6'd60;
    localparam logic [VEC_W-1:0] VEC_OVF = 6'd61;
    localparam logic [VEC_W-1:0] VEC_BRK = 6'd62;

    // One saved frame: whether the entry was a low (shared) vector, and
    // the stack flag value at entry time.
    typedef struct packed {
        logic low;
        logic saved;
    } frame_t;

    typedef struct packed {
        logic             ie;
        logic             stk;
        logic             acc;
        logic [VEC_W-1:0] vec;
    } core_st_t;
endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int NUM_SRC = 32,
    parameter int LVL_W   = 3,
    localparam int IW     = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]       req,
    input  logic [NUM_SRC*LVL_W-1:0] lvl,
    input  logic [LVL_W-1:0]         cpu_lvl,
    input  logic                     en,
    output logic                     valid,
    output logic [IW-1:0]            idx
);
    logic [LVL_W-1:0] best;

    // Scan from the top index down; ">=" lets a lower index replace an
    // equal-level winner, so ties settle on the lowest index.
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (en && req[i] && (lvl[i*LVL_W +: LVL_W] > cpu_lvl) &&
                (!valid || lvl[i*LVL_W +: LVL_W] >= best)) begin
                valid = 1'b1;
                best  = lvl[i*LVL_W +: LVL_W];
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/frame_lifo.sv
module frame_lifo
    import irq_acc_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   push,
    input  logic   pop,
    input  frame_t din,
    output frame_t top,
    output logic   empty,
    output logic   ovf_err
);
    frame_t          mem_d [DEPTH];
    frame_t          mem_q [DEPTH];
    logic [CW-1:0]   cnt_d, cnt_q;
    logic            err_d, err_q;
    logic [CW-1:0]   top_ptr;

    assign empty   = (cnt_q == '0);
    assign top_ptr = cnt_q - CW'(1);
    assign top     = mem_q[top_ptr[AW-1:0]];
    assign ovf_err = err_q;

    always_comb begin
        mem_d = mem_q;
        cnt_d = cnt_q;
        err_d = err_q;
        if (pop && !empty) begin
            cnt_d = cnt_q - CW'(1);
        end
        if (push) begin
            if (cnt_d == CW'(DEPTH)) begin
                err_d = 1'b1;
            end else begin
                mem_d[cnt_d[AW-1:0]] = din;
                cnt_d = cnt_d + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            err_q <= 1'b0;
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            cnt_q <= cnt_d;
            err_q <= err_d;
            mem_q <= mem_d;
        end
    end
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
    import irq_acc_pkg::*;
#(
    parameter int NUM_SRC   = 32,
    parameter int LVL_W     = 3,
    parameter int NEST_DEPTH = 8,
    localparam int IW       = $clog2(NUM_SRC)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       irq_req,
    input  logic [NUM_SRC*LVL_W-1:0] irq_lvl,
    input  logic [LVL_W-1:0]         cpu_lvl,
    input  logic                     ie_we,
    input  logic                     ie_wdata,
    input  logic                     trap_und,
    input  logic                     trap_ovchk,
    input  logic                     ovf_flag,
    input  logic                     trap_brk,
    input  logic                     swi_stb,
    input  logic [VEC_W-1:0]         swi_num,
    input  logic                     ret_stb,
    output logic                     acc_pulse,
    output logic [VEC_W-1:0]         acc_vec,
    output logic                     stk_sel,
    output logic                     ie_flag,
    output logic                     nest_err
);
    core_st_t         st_d, st_q;
    logic             per_valid;
    logic [IW-1:0]    per_idx;
    logic             sw_hit;
    logic [VEC_W-1:0] sw_vec;
    logic             take;
    logic [VEC_W-1:0] take_vec;
    logic             take_low;
    logic             do_pop;
    frame_t           push_frame, top_frame;
    logic             lifo_empty;

    irq_pick #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_pick (
        .req     (irq_req),
        .lvl     (irq_lvl),
        .cpu_lvl (cpu_lvl),
        .en      (st_q.ie),
        .valid   (per_valid),
        .idx     (per_idx)
    );

    frame_lifo #(.DEPTH(NEST_DEPTH)) u_lifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (take),
        .pop     (do_pop),
        .din     (push_frame),
        .top     (top_frame),
        .empty   (lifo_empty),
        .ovf_err (nest_err)
    );

    // Software strobes in fixed order; none of them is masked.
    always_comb begin
        sw_hit = 1'b1;
        if (trap_und)                    sw_vec = VEC_UND;
        else if (trap_ovchk && ovf_flag) sw_vec = VEC_OVF;
        else if (trap_brk)               sw_vec = VEC_BRK;
        else if (swi_stb)                sw_vec = swi_num;
        else begin
            sw_hit = 1'b0;
            sw_vec = '0;
        end
    end

    assign do_pop   = ret_stb;
    assign take     = !ret_stb && (sw_hit || per_valid);
    assign take_vec = sw_hit ? sw_vec : VEC_W'(per_idx);
    assign take_low = (take_vec < VEC_W'(32));
    assign push_frame = '{low: take_low, saved: st_q.stk};

    always_comb begin
        st_d     = st_q;
        st_d.acc = take;
        if (ie_we) begin
            st_d.ie = ie_wdata;
        end
        if (take) begin
            st_d.vec = take_vec;
            if (take_low) begin
                st_d.stk = 1'b0;
            end
        end else if (do_pop && !lifo_empty && top_frame.low) begin
            st_d.stk = top_frame.saved;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{ie: 1'b0, stk: 1'b1, acc: 1'b0, vec: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_pulse = st_q.acc;
    assign acc_vec   = st_q.vec;
    assign stk_sel   = st_q.stk;
    assign ie_flag   = st_q.ie;
endmodule

// File: rtl/irq_acc_chk.sv
module irq_acc_chk #(
    parameter int NUM_SRC = 32,
    parameter int LVL_W   = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     trap_und,
    input logic                     trap_ovchk,
    input logic                     ovf_flag,
    input logic                     trap_brk,
    input logic                     swi_stb,
    input logic                     ret_stb,
    input logic                     acc_pulse,
    input logic [5:0]               acc_vec,
    input logic                     stk_sel,
    input logic                     ie_flag,
    input logic                     nest_err
);
    logic any_sw;
    assign any_sw = trap_und || (trap_ovchk && ovf_flag) || trap_brk || swi_stb;

    AST_LOW_ENTRY_ISTACK: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_pulse && acc_vec < 6'd32) |-> !stk_sel);  // R8

    AST_HIGH_ENTRY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && acc_pulse && acc_vec >= 6'd32) |-> (stk_sel == $past(stk_sel)));  // R9

    AST_NO_ACC_ON_RET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ret_stb)) |-> !acc_pulse);  // R11

    AST_MASKED_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && acc_pulse && !$past(any_sw)) |-> $past(ie_flag));  // R2

    AST_UND_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(trap_und) && !$past(ret_stb)) |-> (acc_pulse && acc_vec == 6'd60));  // R5

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(nest_err)) |-> nest_err);  // R12
endmodule

bind irq_accept_unit irq_acc_chk #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_chk (.*);

// File: tb/irq_accept_unit_tb_top.sv
module irq_accept_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] irq_req;
    logic [95:0] irq_lvl;
    logic [2:0]  cpu_lvl;
    logic        ie_we, ie_wdata;
    logic        trap_und, trap_ovchk, ovf_flag, trap_brk, swi_stb, ret_stb;
    logic [5:0]  swi_num;
    logic        acc_pulse, stk_sel, ie_flag, nest_err;
    logic [5:0]  acc_vec;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    irq_accept_unit dut_i (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_lvl(irq_lvl),
        .cpu_lvl(cpu_lvl), .ie_we(ie_we), .ie_wdata(ie_wdata),
        .trap_und(trap_und), .trap_ovchk(trap_ovchk), .ovf_flag(ovf_flag),
        .trap_brk(trap_brk), .swi_stb(swi_stb), .swi_num(swi_num),
        .ret_stb(ret_stb), .acc_pulse(acc_pulse), .acc_vec(acc_vec),
        .stk_sel(stk_sel), .ie_flag(ie_flag), .nest_err(nest_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        check(act == exp, tag, act, exp);
    endtask

    task automatic clear_in();
        irq_req = '0; ie_we = 0; ie_wdata = 0; trap_und = 0; trap_ovchk = 0;
        ovf_flag = 0; trap_brk = 0; swi_stb = 0; swi_num = '0; ret_stb = 0;
    endtask

    // Inputs were set after a falling edge; pass one rising edge and sample.
    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_lvl(input int i, input logic [2:0] v);
        irq_lvl[i*3 +: 3] = v;
    endtask

    task automatic do_reset();
        clear_in();
        irq_lvl = '0; cpu_lvl = '0;
        rst_n = 0;
        step(); step();
        rst_n = 1;
    endtask

    task automatic set_ie(input logic v);
        ie_we = 1; ie_wdata = v; step(); clear_in();
    endtask

    task automatic swi(input int num);
        swi_stb = 1; swi_num = 6'(num); step();
    endtask

    task automatic ret();
        ret_stb = 1; step(); clear_in();
    endtask

    task automatic t_reset();
        do_reset();
        step();
        chk_eq("R1 stk_sel", stk_sel, 1);
        chk_eq("R1 ie_flag", ie_flag, 0);
        chk_eq("R1 acc_pulse", acc_pulse, 0);
        chk_eq("R1 nest_err", nest_err, 0);
    endtask

    task automatic t_mask();
        do_reset();
        set_lvl(3, 3'd5); irq_req[3] = 1; step();
        chk_eq("R2 masked by ie=0", acc_pulse, 0); clear_in();
        set_ie(1);
        chk_eq("R13 ie write", ie_flag, 1);
        cpu_lvl = 3'd2; set_lvl(4, 3'd2); irq_req[4] = 1; step();
        chk_eq("R2 equal level blocked", acc_pulse, 0); clear_in();
        set_lvl(4, 3'd3); irq_req[4] = 1; step();
        chk_eq("R2 above level taken", acc_pulse, 1);
        chk_eq("R3 vector of source 4", acc_vec, 4); clear_in();
        step();
        chk_eq("R7 pulse one cycle", acc_pulse, 0);
        ret();
        set_ie(0);
        chk_eq("R13 ie cleared", ie_flag, 0);
    endtask

    task automatic t_arb();
        do_reset(); set_ie(1);
        set_lvl(5, 3'd4); set_lvl(9, 3'd6); set_lvl(2, 3'd6);
        irq_req[5] = 1; irq_req[9] = 1; irq_req[2] = 1; step();
        chk_eq("R3 highest level lowest index", acc_vec, 2);
        chk_eq("R7 pulse with vector", acc_pulse, 1); clear_in();
        set_lvl(17, 3'd7); irq_req[17] = 1; irq_req[5] = 1; step();
        chk_eq("R3 highest level wins", acc_vec, 17); clear_in();
    endtask

    task automatic t_sw();
        do_reset(); cpu_lvl = 3'd7;
        set_lvl(1, 3'd7); irq_req[1] = 1; swi(40);
        chk_eq("R4 sw unmasked", acc_pulse, 1);
        chk_eq("R4 sw beats peripheral", acc_vec, 40); clear_in();
        trap_und = 1; step();
        chk_eq("R5 und vector", acc_vec, 60); clear_in();
        trap_ovchk = 1; ovf_flag = 0; step();
        chk_eq("R6 ovchk without flag", acc_pulse, 0); clear_in();
        trap_ovchk = 1; ovf_flag = 1; step();
        chk_eq("R5 ovf vector", acc_vec, 61); clear_in();
        trap_brk = 1; swi_stb = 1; swi_num = 6'd3; step();
        chk_eq("R5 brk over swi", acc_vec, 62); clear_in();
        trap_und = 1; trap_brk = 1; step();
        chk_eq("R5 und over brk", acc_vec, 60); clear_in();
    endtask

    task automatic t_stack();
        do_reset();
        swi(50); clear_in();
        chk_eq("R9 high entry keeps stk", stk_sel, 1);
        ret();
        chk_eq("R9 high return keeps stk", stk_sel, 1);
        swi(7); clear_in();
        chk_eq("R8 low entry vector", acc_vec, 7);
        chk_eq("R8 low entry clears stk", stk_sel, 0);
        swi(45); clear_in();
        chk_eq("R9 nested high keeps 0", stk_sel, 0);
        ret();
        chk_eq("R10 high pop no change", stk_sel, 0);
        ret();
        chk_eq("R10 low pop restores", stk_sel, 1);
        ret();
        chk_eq("R10 empty pop no change", stk_sel, 1);
        ret_stb = 1; swi_stb = 1; swi_num = 6'd9; step();
        chk_eq("R11 no accept on return", acc_pulse, 0);
        chk_eq("R11 stk untouched", stk_sel, 1); clear_in();
    endtask

    task automatic t_nest();
        do_reset();
        for (int k = 0; k < 8; k++) begin
            swi(5); clear_in();
        end
        chk_eq("R12 eight frames no error", nest_err, 0);
        swi(5); clear_in();
        chk_eq("R12 ninth frame error", nest_err, 1);
        for (int k = 0; k < 7; k++) ret();
        chk_eq("R12 inner frames saved 0", stk_sel, 0);
        ret();
        chk_eq("R12 outer frame restores", stk_sel, 1);
        chk_eq("R12 error sticky", nest_err, 1);
        do_reset(); step();
        chk_eq("R1 reset clears error", nest_err, 0);
    endtask

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        clear_in(); irq_lvl = '0; cpu_lvl = '0; rst_n = 0;
        step();
        t_reset();
        t_mask();
        t_arb();
        t_sw();
        t_stack();
        t_nest();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule